// File: doc/BRIEF.md
# Fixed-Length Burst Address Sequencer

This block sits on the manager side of an AHB bus and turns one burst request into the per-beat address phase. A request gives a start address, a transfer size and a burst type. The block then drives the address, the transfer type, the burst code and the size for every beat of an incrementing or wrapping burst of 4, 8 or 16 beats. It moves to the next beat only when the bus reports ready. It reports the end of a burst with a one-cycle pulse once the final beat has been accepted.

Wrapping bursts begin at the requested word, which is the critical word of a cache line fill. They keep every beat inside an aligned window whose size is the beat count times the beat size, and only the address bits below that window change. Incrementing bursts step linearly and may cross any block edge. A request with an illegal size, an unsupported burst code or a start address that is not aligned to the beat size is refused and flagged, and nothing is issued.

Top module: `burst_addr_seq`

## Requirements
- R1: After synchronous reset, htrans is IDLE (00), done is 0 and reject is 0.
- R2: When the block is idle and start is high with a legal request, then from the next cycle haddr equals start_addr, htrans is NONSEQ (10), hburst equals req_burst and hsize equals req_size.
- R3: A burst issues exactly as many beats as its code declares: 010/011 give 4 beats, 100/101 give 8 beats, 110/111 give 16 beats. Every beat after the first is SEQ (11).
- R4: For an incrementing code (bit 0 set: 011, 101, 111), each accepted beat adds the beat size to the address, with no wrapping. Sizes 000/001/010 mean 1, 2 and 4 byte beats. An INCR16 of words from 0x08 runs 0x08 up to 0x44.
- R5: For a wrapping code (bit 0 clear: 010, 100, 110), the address stays inside the aligned window of beats times beat size. The bits above the window are held, and the first beat is the requested address. A WRAP16 of words from 0x08 runs 0x08 to 0x3C, then 0x00 and 0x04.
- R6: While a beat is presented and hready is low, haddr, htrans and the count of remaining beats hold.
- R7: In the cycle after the last beat is accepted, htrans is IDLE and done is 1, and done is 1 for that one cycle only.
- R8: A request whose start_addr is not a multiple of the beat size, whose req_size is above 010, or whose req_burst is 000 or 001 gives reject = 1 for one cycle in the next cycle. htrans stays IDLE.
- R9: start is ignored while a burst is in progress, and the running burst continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a burst (taken only when idle) |
| start_addr | input | ADDR_W | Start (critical) address |
| req_size | input | 3 | Requested transfer size code |
| req_burst | input | 3 | Requested burst code |
| hready | input | 1 | Bus ready: the current beat is accepted |
| haddr | output | ADDR_W | Beat address |
| htrans | output | 2 | Transfer type (IDLE, NONSEQ, SEQ) |
| hburst | output | 3 | Burst code of the running burst |
| hsize | output | 3 | Size code of the running burst |
| done | output | 1 | One-cycle pulse after the last beat is accepted |
| reject | output | 1 | One-cycle pulse for a refused request |

## Verification
A wrong wrap mask or step value shows on haddr at the first beat that crosses the window top or leaves the expected stride. The bench compares every beat address against a model that computes the offset modulo the window, so this is caught within the burst. A beat counter that is off by one ends the burst a beat early or late, and the IDLE or done check in the cycle after the final expected beat catches it. A counter or address that moves during a wait state appears as an address mismatch on the repeated check in the very next cycle.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_t;

  localparam int MAX_BEATS    = 16;
  localparam int CNT_W        = $clog2(MAX_BEATS);
  localparam int MAX_SIZE_LOG = 2;
endpackage

// File: rtl/burst_decode.sv
module burst_decode
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic [2:0]        burst,
  output logic              legal,
  output logic              is_wrap,
  output logic [CNT_W-1:0]  last_idx,
  output logic [ADDR_W-1:0] step,
  output logic [ADDR_W-1:0] win_mask
);
  logic [CNT_W:0]      beats;
  logic [ADDR_W-1:0]   win;
  logic                aligned;

  always_comb begin
    case (burst[2:1])
      2'b01:   beats = (CNT_W+1)'(4);
      2'b10:   beats = (CNT_W+1)'(8);
      2'b11:   beats = (CNT_W+1)'(16);
      default: beats = '0;
    endcase
  end

  assign step     = ADDR_W'(1) << size;
  assign win      = {{(ADDR_W-CNT_W-1){1'b0}}, beats} << size;
  assign win_mask = win - ADDR_W'(1);
  assign aligned  = (addr & (step - ADDR_W'(1))) == '0;
  assign is_wrap  = ~burst[0];
  assign last_idx = CNT_W'(beats - (CNT_W+1)'(1));
  assign legal    = (burst[2:1] != 2'b00) && (size <= 3'(MAX_SIZE_LOG)) && aligned;
endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] step,
  input  logic [ADDR_W-1:0] win_mask,
  input  logic              is_wrap,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] sum;

  assign sum = addr + step;

  always_comb begin
    if (is_wrap) nxt = (addr & ~win_mask) | (sum & win_mask);
    else         nxt = sum;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [2:0]        req_size,
  input  logic [2:0]        req_burst,
  input  logic              hready,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic [2:0]        hburst,
  output logic [2:0]        hsize,
  output logic              done,
  output logic              reject
);
  logic              dec_legal, dec_wrap;
  logic [CNT_W-1:0]  dec_last;
  logic [ADDR_W-1:0] dec_step, dec_mask;

  logic              active_q, wrap_q, done_q, reject_q;
  logic [ADDR_W-1:0] addr_q, step_q, mask_q, addr_nxt;
  logic [CNT_W-1:0]  left_q;
  trans_t            trans_q;
  logic [2:0]        burst_q, size_q;

  burst_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (start_addr),
    .size     (req_size),
    .burst    (req_burst),
    .legal    (dec_legal),
    .is_wrap  (dec_wrap),
    .last_idx (dec_last),
    .step     (dec_step),
    .win_mask (dec_mask)
  );

  burst_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
    .addr     (addr_q),
    .step     (step_q),
    .win_mask (mask_q),
    .is_wrap  (wrap_q),
    .nxt      (addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      trans_q  <= TR_IDLE;
      addr_q   <= '0;
      step_q   <= '0;
      mask_q   <= '0;
      wrap_q   <= 1'b0;
      left_q   <= '0;
      burst_q  <= '0;
      size_q   <= '0;
      done_q   <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      reject_q <= 1'b0;
      if (!active_q) begin
        if (start) begin
          if (dec_legal) begin
            active_q <= 1'b1;
            trans_q  <= TR_NONSEQ;
            addr_q   <= start_addr;
            step_q   <= dec_step;
            mask_q   <= dec_mask;
            wrap_q   <= dec_wrap;
            left_q   <= dec_last;
            burst_q  <= req_burst;
            size_q   <= req_size;
          end else begin
            reject_q <= 1'b1;
          end
        end
      end else if (hready) begin
        if (left_q == '0) begin
          active_q <= 1'b0;
          trans_q  <= TR_IDLE;
          done_q   <= 1'b1;
        end else begin
          trans_q  <= TR_SEQ;
          addr_q   <= addr_nxt;
          left_q   <= left_q - CNT_W'(1);
        end
      end
    end
  end

  assign haddr  = addr_q;
  assign htrans = trans_q;
  assign hburst = burst_q;
  assign hsize  = size_q;
  assign done   = done_q;
  assign reject = reject_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              hready,
  input logic [ADDR_W-1:0] haddr,
  input logic [1:0]        htrans,
  input logic [2:0]        hburst,
  input logic [2:0]        hsize,
  input logic              done,
  input logic              reject
);
  logic [CNT_W:0]      c_beats;
  logic [ADDR_W-1:0]   c_step, c_mask;

  always_comb begin
    case (hburst[2:1])
      2'b01:   c_beats = (CNT_W+1)'(4);
      2'b10:   c_beats = (CNT_W+1)'(8);
      2'b11:   c_beats = (CNT_W+1)'(16);
      default: c_beats = '0;
    endcase
  end
  assign c_step = ADDR_W'(1) << hsize;
  assign c_mask = ({{(ADDR_W-CNT_W-1){1'b0}}, c_beats} << hsize) - ADDR_W'(1);

  // R6
  hold_on_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (htrans != TR_IDLE && !hready) |=> ($stable(haddr) && $stable(htrans)));

  // R3
  seq_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (htrans != TR_IDLE && hready) |=> (htrans == TR_SEQ || htrans == TR_IDLE));

  // R3
  no_busy_chk: assert property (@(posedge clk) disable iff (rst)
    htrans != TR_BUSY);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (htrans == TR_IDLE));

  // R4
  incr_stride_chk: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_SEQ && hburst[0] && $past(hready)) |-> (haddr == $past(haddr) + c_step));

  // R5
  wrap_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_SEQ && !hburst[0]) |-> ((haddr & ~c_mask) == ($past(haddr) & ~c_mask)));

  // R8
  reject_idle_chk: assert property (@(posedge clk) disable iff (rst)
    reject |-> (htrans == TR_IDLE));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [AW-1:0] start_addr;
  logic [2:0]    req_size, req_burst;
  logic          hready;
  logic [AW-1:0] haddr;
  logic [1:0]    htrans;
  logic [2:0]    hburst, hsize;
  logic          done, reject;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  burst_addr_seq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .req_size(req_size), .req_burst(req_burst), .hready(hready),
    .haddr(haddr), .htrans(htrans), .hburst(hburst), .hsize(hsize),
    .done(done), .reject(reject)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int nbeats(input logic [2:0] br);
    case (br[2:1])
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [AW-1:0] model_addr(input logic [AW-1:0] a, input logic [2:0] sz,
                                               input logic [2:0] br, input int i);
    logic [AW-1:0] st, len, base;
    st = AW'(1) << sz;
    if (br[0]) return a + AW'(i) * st;
    len  = AW'(nbeats(br)) * st;
    base = a & ~(len - 1);
    return base + (((a - base) + AW'(i) * st) % len);
  endfunction

  task automatic run_burst(input logic [AW-1:0] a, input logic [2:0] sz,
                           input logic [2:0] br, input int wait_pct, input bit poke);
    string tag;
    bit hr;
    int n;
    n = nbeats(br);
    start = 1; start_addr = a; req_size = sz; req_burst = br;
    @(negedge clk);
    start = 0;
    check("R2 hburst", AW'(hburst), AW'(br));
    check("R2 hsize", AW'(hsize), AW'(sz));
    check("R8 no reject on legal", AW'(reject), 0);
    for (int i = 0; i < n; i++) begin
      tag = (i == 0) ? "R2 first beat" : (br[0] ? "R4 incr addr" : "R5 wrap addr");
      forever begin
        check({tag, " haddr"}, haddr, model_addr(a, sz, br, i));
        check("R3 htrans", AW'(htrans), (i == 0) ? AW'(2'b10) : AW'(2'b11));
        check("R7 done low mid-burst", AW'(done), 0);
        hr = ($urandom % 100) >= wait_pct;
        if (poke && i == 2) begin
          start = 1; start_addr = a + 32'h100; req_size = 3'd0; req_burst = 3'b011;
        end
        hready = hr;
        @(negedge clk);
        start = 0;
        if (poke && i == 2) tag = "R9 busy start ignored";
        if (hr) break;
        tag = "R6 held on wait";
      end
    end
    check("R3 idle after last beat", AW'(htrans), 0);
    check("R7 done pulse", AW'(done), 1);
    hready = 1;
    @(negedge clk);
    check("R7 done one cycle", AW'(done), 0);
    check("R7 stays idle", AW'(htrans), 0);
  endtask

  task automatic run_reject(input logic [AW-1:0] a, input logic [2:0] sz, input logic [2:0] br);
    start = 1; start_addr = a; req_size = sz; req_burst = br;
    @(negedge clk);
    start = 0;
    check("R8 reject pulse", AW'(reject), 1);
    check("R8 not issued", AW'(htrans), 0);
    @(negedge clk);
    check("R8 reject one cycle", AW'(reject), 0);
    check("R8 still idle", AW'(htrans), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; start = 0; start_addr = '0; req_size = '0; req_burst = '0; hready = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 htrans idle", AW'(htrans), 0);
    check("R1 done low", AW'(done), 0);
    check("R1 reject low", AW'(reject), 0);

    run_burst(32'h08, 3'd2, 3'b111, 0, 0);
    run_burst(32'h08, 3'd2, 3'b110, 0, 0);
    run_burst(32'h3C, 3'd2, 3'b110, 40, 0);
    run_burst(32'h1E, 3'd1, 3'b010, 30, 1);
    run_burst(32'h1D, 3'd0, 3'b100, 50, 0);
    run_burst(32'hFFFF_FFF8, 3'd2, 3'b011, 20, 1);
    run_burst(32'h1000_0074, 3'd2, 3'b100, 30, 0);

    run_reject(32'h02, 3'd2, 3'b010);
    run_reject(32'h01, 3'd1, 3'b111);
    run_reject(32'h40, 3'd3, 3'b110);
    run_reject(32'h40, 3'd2, 3'b000);
    run_reject(32'h40, 3'd2, 3'b001);

    for (int k = 0; k < 40; k++) begin
      logic [2:0] sz, br;
      logic [AW-1:0] a;
      sz = 3'($urandom % 3);
      br = 3'(2 + ($urandom % 6));
      a  = $urandom & ~((AW'(1) << sz) - 1);
      run_burst(a, sz, br, 30, (k % 5) == 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule